// File: doc/BRIEF.md
# Audio Serial Receive Path

This block takes audio samples from a three-wire synchronous serial input: a bit clock, a frame sync and a data line. The block runs in the system clock domain. It oversamples the serial lines through a synchronizer and acts on each rising edge of the bit clock. A frame is a single time slot, and the frame sync stays high for the whole data word. The block shifts each sample in most-significant bit first. The word is 8 or 16 bits long, as configured.

A route bit decides where each completed sample goes. With the route bit clear, the sample is pushed into an eight-entry receive FIFO. The CPU drains the FIFO through a show-ahead read port. An interrupt line is raised while the fill count is strictly above a programmable warning limit. With the route bit set, the sample goes to one holding register that a DMA engine drains. A request line is high while that register holds a sample, and a read acknowledge empties it. A sample that arrives while its destination is full is dropped, and a sticky overrun flag records the loss.

Top module: `audio_rx`

## Requirements
- R1: After reset, fifo_count is 0 and irq, dma_req and overrun are all low.
- R2: With cfg_wide16=1, the 16 data bits sampled on consecutive rising ser_clk edges while ser_fs is high form one sample, with the first bit in bit 15.
- R3: With cfg_wide16=0, 8 bits form one sample, placed in bits 7:0 of the read data with bits 15:8 zero.
- R4: If ser_fs drops before a word is complete, the partial bits are discarded and the next frame starts a fresh word.
- R5: With cfg_dma_route=0, each accepted sample is pushed into the FIFO, and fifo_count tracks the entries. cpu_rdata shows the oldest entry, and a cpu_rd pulse removes it, so samples come out in arrival order.
- R6: irq is high exactly when fifo_count is strictly greater than cfg_warn_lim.
- R7: With cfg_dma_route=1, a sample is loaded into the DMA holding register (dma_rdata) and not into the FIFO. dma_req is high while that register is full.
- R8: A dma_ack pulse while dma_req is high empties the holding register, so dma_req is low on the next cycle.
- R9: A sample arriving with 8 entries in the FIFO is dropped, leaving the FIFO contents unchanged, and overrun becomes 1.
- R10: A sample arriving while the DMA holding register is full is dropped, dma_rdata keeps its value, and overrun becomes 1.
- R11: overrun stays set until an ovr_clr pulse clears it.
- R12: Samples are accepted only when cfg_slots (slot count field) is 00 and cfg_slot_sel is 00. Otherwise completed words reach neither the FIFO nor the DMA register.
- R13: A cpu_rd pulse with the FIFO empty has no effect; fifo_count stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock (asynchronous, oversampled) |
| ser_fs | input | 1 | Long frame sync, high during the data word |
| ser_data | input | 1 | Serial data, MSB first |
| cfg_dma_route | input | 1 | 0: FIFO delivery, 1: DMA register delivery |
| cfg_wide16 | input | 1 | 1: 16-bit samples, 0: 8-bit samples |
| cfg_slots | input | 2 | Slot count field; must be 00 for normal mode |
| cfg_slot_sel | input | 2 | Receive slot assignment; must be 00 |
| cfg_warn_lim | input | 3 | FIFO warning limit, 0 to 7 |
| cpu_rd | input | 1 | Pop the FIFO head |
| cpu_rdata | output | 16 | FIFO head sample |
| fifo_count | output | 4 | FIFO fill count, 0 to 8 |
| irq | output | 1 | FIFO above warning limit |
| dma_ack | input | 1 | DMA read acknowledge, empties the holding register |
| dma_rdata | output | 16 | DMA holding register contents |
| dma_req | output | 1 | DMA holding register full |
| ovr_clr | input | 1 | Clear the overrun flag |
| overrun | output | 1 | Sticky sample-lost flag |

## Verification
The bench sends 16-bit words whose bit patterns differ at both ends, to separate MSB-first from LSB-first assembly and to catch lost end bits. It sends 8-bit words, to show that narrow samples are zero-extended and not merged with stale shift-register bits. It cuts a frame short, to show that partial bits are discarded. It sends the same traffic through each route and with the slot fields moved off zero. Filling the FIFO past the limit and then past its depth, and sending into a full DMA register, separates the strict threshold from an at-or-above threshold, and dropping a sample from overwriting a stored one.

// File: rtl/audio_rx_pkg.sv
// Package: shared constants and types for the audio serial receive path.
// Assumes: one slot per frame; sample widths of 8 or 16 bits.
package audio_rx_pkg;
    localparam int SAMPLE_W   = 16;
    localparam int NARROW_W   = 8;
    localparam int RX_DEPTH   = 8;

    typedef enum logic {
        ROUTE_FIFO = 1'b0,
        ROUTE_DMA  = 1'b1
    } route_e;
endpackage

// File: rtl/audio_rx_front.sv
// Module: audio_rx_front
// Synchronizes the serial lines into the system clock domain and detects
// rising bit-clock edges. It assembles MSB-first samples while the frame
// sync is high. It emits a one-cycle word_vld pulse with the completed sample.
// Assumes: the bit clock is at most a quarter of the system clock rate, and
// data and frame sync are stable around the rising bit-clock edge.
module audio_rx_front #(
    parameter int DATA_W      = 16,
    parameter int NARROW_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_fs,
    input  logic              ser_data,
    input  logic              wide,
    output logic              word_vld,
    output logic [DATA_W-1:0] word_data
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(NARROW_W - 1);

    logic [2:0] sync_q [SYNC_STAGES];
    logic       clk_s, fs_s, dat_s;
    logic       clk_prev;
    logic       rise;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] next_word;
    logic [CNT_W-1:0]  last_bit;

    // One register stage per synchronizer step, generated from the depth.
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                // First stage: capture the raw serial lines.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[s] <= 3'b000;
                    else        sync_q[s] <= {ser_clk, ser_fs, ser_data};
                end
            end else begin : g_next
                // Later stages: pass the previous stage along.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[s] <= 3'b000;
                    else        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    // Split the synchronized bundle and derive the rising bit-clock edge.
    always_comb begin
        clk_s     = sync_q[SYNC_STAGES-1][2];
        fs_s      = sync_q[SYNC_STAGES-1][1];
        dat_s     = sync_q[SYNC_STAGES-1][0];
        rise      = clk_s & ~clk_prev;
        last_bit  = wide ? LAST_WIDE : LAST_NARROW;
        next_word = {shreg[DATA_W-2:0], dat_s};
    end

    // Remember the previous synchronized bit clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= clk_s;
    end

    // Shift in bits while framed; emit a word when the last bit arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            word_vld  <= 1'b0;
            word_data <= '0;
        end else begin
            word_vld <= 1'b0;
            if (!fs_s) begin
                bit_cnt <= '0;
                shreg   <= '0;
            end else if (rise) begin
                if (bit_cnt == last_bit) begin
                    bit_cnt   <= '0;
                    shreg     <= '0;
                    word_vld  <= 1'b1;
                    word_data <= wide ? next_word
                                      : DATA_W'(next_word[NARROW_W-1:0]);
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                    shreg   <= next_word;
                end
            end
        end
    end
endmodule

// File: rtl/audio_rx_fifo.sv
// Module: audio_rx_fifo
// Show-ahead synchronous FIFO holding received samples for the CPU.
// Assumes: the caller never pushes when full without a pop in the same
// cycle; a pop on empty is ignored here.
module audio_rx_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              do_pop;
    logic              do_push;

    // Qualify push and pop against the occupancy.
    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        do_pop  = pop && (count != '0);
        do_push = push && (!full || do_pop);
        head    = mem[rd_ptr];
    end

    // Storage write port.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/audio_rx_dma_buf.sv
// Module: audio_rx_dma_buf
// Single holding register for DMA delivery with a full flag that doubles
// as the DMA request. An acknowledge empties it.
// Assumes: the caller loads only when the register is empty or being acked.
module audio_rx_dma_buf #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              ack,
    output logic [DATA_W-1:0] data,
    output logic              full
);
    // Hold the sample and track occupancy; a load wins over an ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            full <= 1'b0;
        end else if (load) begin
            data <= load_data;
            full <= 1'b1;
        end else if (ack) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/audio_rx.sv
// Module: audio_rx (top)
// Audio serial receive path: assembles framed serial samples, then routes
// each to a threshold-interrupt FIFO or a DMA holding register. It flags
// samples lost to a full destination.
// Assumes: normal mode only (one slot per frame); configuration is held
// steady while a frame is in flight.
module audio_rx
    import audio_rx_pkg::*;
#(
    parameter int DATA_W      = SAMPLE_W,
    parameter int FIFO_DEPTH  = RX_DEPTH,
    parameter int SYNC_STAGES = 2,
    parameter int LIM_W       = $clog2(FIFO_DEPTH),
    parameter int CNT_W       = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_fs,
    input  logic              ser_data,
    input  logic              cfg_dma_route,
    input  logic              cfg_wide16,
    input  logic [1:0]        cfg_slots,
    input  logic [1:0]        cfg_slot_sel,
    input  logic [LIM_W-1:0]  cfg_warn_lim,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [CNT_W-1:0]  fifo_count,
    output logic              irq,
    input  logic              dma_ack,
    output logic [DATA_W-1:0] dma_rdata,
    output logic              dma_req,
    input  logic              ovr_clr,
    output logic              overrun
);
    logic              word_vld;
    logic [DATA_W-1:0] word_data;
    logic              slot_ok;
    logic              accept;
    logic              fifo_full;
    logic              fifo_push;
    logic              dma_load;
    logic              ovr_set;
    route_e            route;

    audio_rx_front #(
        .DATA_W      (DATA_W),
        .NARROW_W    (NARROW_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_fs    (ser_fs),
        .ser_data  (ser_data),
        .wide      (cfg_wide16),
        .word_vld  (word_vld),
        .word_data (word_data)
    );

    // Decide where a completed word goes and whether it is lost.
    always_comb begin
        route     = route_e'(cfg_dma_route);
        slot_ok   = (cfg_slots == 2'b00) && (cfg_slot_sel == 2'b00);
        accept    = word_vld && slot_ok;
        fifo_push = accept && (route == ROUTE_FIFO) && (!fifo_full || cpu_rd);
        dma_load  = accept && (route == ROUTE_DMA) && (!dma_req || dma_ack);
        ovr_set   = accept && !fifo_push && !dma_load;
    end

    audio_rx_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (FIFO_DEPTH),
        .CNT_W  (CNT_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (word_data),
        .pop       (cpu_rd),
        .head      (cpu_rdata),
        .count     (fifo_count),
        .full      (fifo_full)
    );

    audio_rx_dma_buf #(
        .DATA_W (DATA_W)
    ) u_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (dma_load),
        .load_data (word_data),
        .ack       (dma_ack),
        .data      (dma_rdata),
        .full      (dma_req)
    );

    // Strictly-greater warning comparison for the receive interrupt.
    always_comb begin
        irq = fifo_count > CNT_W'(cfg_warn_lim);
    end

    // Sticky overrun flag; a new loss outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       overrun <= 1'b0;
        else if (ovr_set) overrun <= 1'b1;
        else if (ovr_clr) overrun <= 1'b0;
    end
endmodule

// File: rtl/audio_rx_checker.sv
// Module: audio_rx_checker
// Temporal properties of the receive path, bound into every audio_rx.
module audio_rx_checker #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_rd,
    input logic [CNT_W-1:0]  fifo_count,
    input logic              irq,
    input logic              dma_ack,
    input logic              dma_req,
    input logic [DATA_W-1:0] dma_rdata,
    input logic              ovr_clr,
    input logic              overrun,
    input logic              fifo_push,
    input logic              dma_load,
    input logic              ovr_set
);
    // R5: occupancy never exceeds the depth.
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    // R5: with no push and no pop the count holds.
    assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_push && !cpu_rd) |=> $stable(fifo_count));

    // R6: an empty FIFO never raises the interrupt.
    assert_irq_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> fifo_count != '0);

    // R8: an ack with no new load empties the DMA register.
    assert_dma_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack && !dma_load) |=> !dma_req);

    // R10: an unacknowledged full DMA register keeps request and value.
    assert_dma_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> (dma_req && $stable(dma_rdata)));

    // R9: a lost sample raises overrun.
    assert_ovr_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |=> overrun);

    // R11: overrun stays until cleared.
    assert_ovr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    // R11: a clear with no new loss drops the flag.
    assert_ovr_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !ovr_set) |=> !overrun);

    // R13: a read of an empty FIFO leaves it empty.
    assert_empty_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && fifo_count == '0 && !fifo_push) |=> fifo_count == '0);
endmodule

bind audio_rx audio_rx_checker #(
    .DATA_W (DATA_W),
    .DEPTH  (FIFO_DEPTH),
    .CNT_W  (CNT_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_rd     (cpu_rd),
    .fifo_count (fifo_count),
    .irq        (irq),
    .dma_ack    (dma_ack),
    .dma_req    (dma_req),
    .dma_rdata  (dma_rdata),
    .ovr_clr    (ovr_clr),
    .overrun    (overrun),
    .fifo_push  (fifo_push),
    .dma_load   (dma_load),
    .ovr_set    (ovr_set)
);

// File: tb/audio_rx_tb.sv
// Bench: behavioural queue model of the receive path, compared on every
// settled clock and at named checkpoints.
module audio_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_fs = 1'b0, ser_data = 1'b0;
    logic        cfg_dma_route = 1'b0, cfg_wide16 = 1'b1;
    logic [1:0]  cfg_slots = 2'b00, cfg_slot_sel = 2'b00;
    logic [2:0]  cfg_warn_lim = 3'd2;
    logic        cpu_rd = 1'b0, dma_ack = 1'b0, ovr_clr = 1'b0;
    logic [15:0] cpu_rdata, dma_rdata;
    logic [3:0]  fifo_count;
    logic        irq, dma_req, overrun;

    int checks = 0;
    int failures = 0;
    bit settled = 1'b0;

    // Reference model state.
    int m_q[$];
    bit m_dma_full = 1'b0;
    int m_dma_val = 0;
    bit m_ovr = 1'b0;

    always #2 clk = ~clk;

    audio_rx u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_fs(ser_fs),
        .ser_data(ser_data), .cfg_dma_route(cfg_dma_route),
        .cfg_wide16(cfg_wide16), .cfg_slots(cfg_slots),
        .cfg_slot_sel(cfg_slot_sel), .cfg_warn_lim(cfg_warn_lim),
        .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .fifo_count(fifo_count),
        .irq(irq), .dma_ack(dma_ack), .dma_rdata(dma_rdata),
        .dma_req(dma_req), .ovr_clr(ovr_clr), .overrun(overrun)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare every observable output with the model.
    task automatic cmp_all(input string tag);
        cmp({tag, " R5 fifo_count"}, fifo_count, m_q.size());
        cmp({tag, " R6 irq"}, irq, (m_q.size() > int'(cfg_warn_lim)) ? 1 : 0);
        cmp({tag, " R7 dma_req"}, dma_req, m_dma_full);
        cmp({tag, " R11 overrun"}, overrun, m_ovr);
        if (m_q.size() > 0) cmp({tag, " R5 cpu_rdata"}, cpu_rdata, m_q[0]);
        if (m_dma_full) cmp({tag, " R7 dma_rdata"}, dma_rdata, m_dma_val);
    endtask

    // Per-clock comparison while no transfer is in flight.
    always @(negedge clk) begin
        if (settled && rst_n) cmp_all("clk");
    end

    // Model: deliver one completed word.
    task automatic model_word(input int val);
        if (cfg_slots != 2'b00 || cfg_slot_sel != 2'b00) return;
        if (cfg_dma_route) begin
            if (m_dma_full) m_ovr = 1'b1;
            else begin m_dma_full = 1'b1; m_dma_val = val; end
        end else begin
            if (m_q.size() == 8) m_ovr = 1'b1;
            else m_q.push_back(val);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive nbits of val MSB first inside one frame; complete=0 cuts it short.
    task automatic send(input int val, input int nbits, input int sent, input bit complete);
        settled = 1'b0;
        @(negedge clk);
        ser_fs = 1'b1;
        for (int i = nbits - 1; i >= nbits - sent; i--) begin
            ser_data = val[i];
            ser_clk  = 1'b0;
            idle(3);
            ser_clk  = 1'b1;
            idle(3);
        end
        ser_fs  = 1'b0;
        ser_clk = 1'b0;
        idle(10);
        if (complete) model_word(val & ((1 << nbits) - 1));
        settled = 1'b1;
    endtask

    task automatic cpu_read(input string tag, input int exp);
        settled = 1'b0;
        @(negedge clk);
        if (exp >= 0) cmp(tag, cpu_rdata, exp);
        cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        if (m_q.size() > 0) void'(m_q.pop_front());
        settled = 1'b1;
    endtask

    task automatic pulse_ack();
        settled = 1'b0;
        @(negedge clk);
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
        m_dma_full = 1'b0;
        settled = 1'b1;
    endtask

    task automatic pulse_clr();
        settled = 1'b0;
        @(negedge clk);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        m_ovr = 1'b0;
        settled = 1'b1;
    endtask

    bit done = 1'b0;

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R1: reset state.
        cmp("R1 fifo_count", fifo_count, 0);
        cmp("R1 irq", irq, 0);
        cmp("R1 dma_req", dma_req, 0);
        cmp("R1 overrun", overrun, 0);
        settled = 1'b1;

        // R2/R5/R6: 16-bit words into the FIFO, limit 2.
        send(16'hA5C3, 16, 16, 1'b1);
        send(16'h1234, 16, 16, 1'b1);
        cmp("R6 irq low at count==limit", irq, 0);
        send(16'h8001, 16, 16, 1'b1);
        cmp("R6 irq high at count>limit", irq, 1);
        cpu_read("R2 first word MSB-first", 16'hA5C3);
        cpu_read("R5 order second", 16'h1234);
        cpu_read("R2 end bits", 16'h8001);

        // R3: narrow samples zero-extended.
        cfg_wide16 = 1'b0;
        send(8'h5A, 8, 8, 1'b1);
        send(8'hC1, 8, 8, 1'b1);
        cpu_read("R3 narrow first", 16'h005A);
        cpu_read("R3 narrow second", 16'h00C1);
        cfg_wide16 = 1'b1;

        // R4: aborted frame discarded, next frame clean.
        send(16'hFFFF, 16, 5, 1'b0);
        cmp("R4 partial not delivered", fifo_count, 0);
        send(16'h0F0F, 16, 16, 1'b1);
        cpu_read("R4 fresh word after abort", 16'h0F0F);

        // R13: read on empty.
        cpu_read("R13 empty read", -1);
        cmp("R13 count stays 0", fifo_count, 0);

        // R9/R6: fill to 8, limit 7, then overflow.
        cfg_warn_lim = 3'd7;
        for (int k = 0; k < 7; k++) send(16'h1000 + k, 16, 16, 1'b1);
        cmp("R6 irq low at 7 with limit 7", irq, 0);
        send(16'h1007, 16, 16, 1'b1);
        cmp("R6 irq high at 8", irq, 1);
        send(16'hDEAD, 16, 16, 1'b1);
        cmp("R9 overrun set", overrun, 1);
        cmp("R9 count still 8", fifo_count, 8);
        for (int k = 0; k < 8; k++) cpu_read("R9 contents kept", 16'h1000 + k);
        idle(3);
        cmp("R11 overrun sticky", overrun, 1);
        pulse_clr();
        cmp("R11 overrun cleared", overrun, 0);

        // R7/R8/R10: DMA route.
        cfg_dma_route = 1'b1;
        send(16'h3C5A, 16, 16, 1'b1);
        cmp("R7 dma_req", dma_req, 1);
        cmp("R7 dma_rdata", dma_rdata, 16'h3C5A);
        cmp("R7 fifo untouched", fifo_count, 0);
        send(16'h7777, 16, 16, 1'b1);
        cmp("R10 dma_rdata kept", dma_rdata, 16'h3C5A);
        cmp("R10 overrun", overrun, 1);
        pulse_ack();
        cmp("R8 dma_req cleared", dma_req, 0);
        pulse_clr();
        send(16'h2468, 16, 16, 1'b1);
        cmp("R7 reload after ack", dma_rdata, 16'h2468);
        pulse_ack();

        // R12: slot fields off zero block delivery.
        cfg_slots = 2'b01;
        send(16'hBEEF, 16, 16, 1'b1);
        cmp("R12 slots no dma", dma_req, 0);
        cfg_slots = 2'b00;
        cfg_dma_route = 1'b0;
        cfg_slot_sel = 2'b10;
        send(16'hBEEF, 16, 16, 1'b1);
        cmp("R12 slot_sel no fifo", fifo_count, 0);
        cmp("R12 no overrun", overrun, 0);
        cfg_slot_sel = 2'b00;
        idle(4);

        done = 1'b1;
        settled = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule